// File: doc/BRIEF.md
# System Segment Register Loader

This block is the sequencer that fills either the local descriptor table register or the task register from a 16-bit selector. A one-cycle start pulse carries the target select, the selector, the current privilege level, a long-mode flag and the base address of the global descriptor table. Before it touches memory, the block screens the selector. It then fetches the descriptor over a simple request/acknowledge memory port. In long mode it fetches a third word, which supplies the upper half of the base. It checks the descriptor type, then the present bit. If both pass, it commits the selector, base, limit and type to the chosen register.

A task-register load has one more step. Before it reports completion, it writes the descriptor's high word back to memory with the busy flag set. Every operation ends with a one-cycle `done` pulse together with a fault code and a 16-bit error code. A faulting operation leaves both registers as they were. Decoding the instruction and delivering the exception are left to the surrounding core.

Top module: `sysreg_loader`

## Requirements
- R1: After reset both registers read as invalid with selector, base, limit and type zero, `fault` is 0 (none), and `busy`, `done` and `mem_req` are low.
- R2: A start with `cpl` not zero completes with `fault` = 1 (general protection) and `fault_err` = 0. It makes no memory access, and this check takes precedence over every other check.
- R3: A local-table load whose selector has bits 15:2 all zero makes no memory access. It stores the selector, clears the valid flag and completes with `fault` = 0.
- R4: A task-register load whose selector has bits 15:2 all zero completes with `fault` = 1 and `fault_err` = 0.
- R5: A non-null selector with bit 2 set completes with `fault` = 1 and `fault_err` equal to the selector with bits 1:0 cleared. This check comes after the privilege check and after the null check.
- R6: The low descriptor word is read at `table_base` + 8×selector[15:3] and the high word at that address + 4. Only in long mode is a third word read at + 8, and it becomes base bits 63:32. Otherwise those bits are zero.
- R7: The high word's bit 12 must be 0, and its bits 11:8 must be 2 for a local-table load, or 1 or 9 for a task-register load. Anything else completes with `fault` = 1 and the masked selector as `fault_err`.
- R8: A descriptor that passes R7 but has high-word bit 15 clear completes with `fault` = 2 (not present) and the masked selector as `fault_err`. A descriptor that fails both checks reports the type fault.
- R9: A successful task-register load writes the high word with bit 9 set to `table_base` + 8×index + 4, and reports `done` only after that write is acknowledged.
- R10: On success the register holds the selector, type = high[11:8], valid = 1, base = {ext, high[31:24], high[7:0], low[31:16]}, and limit = {high[19:16], low[15:0]}. When high bit 23 is set, the limit is instead shifted left 12 with 0xFFF filled in below.
- R11: `done` is a single-cycle pulse. When it reports a nonzero `fault`, the selector and valid flag of both registers are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted while not busy) |
| load_tr | input | 1 | 0 = local-table register, 1 = task register |
| selector | input | 16 | Selector to load |
| cpl | input | CPL_W | Current privilege level |
| long_mode | input | 1 | Fetch the third descriptor word |
| table_base | input | ADDR_W | Global descriptor table base address |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 2 | 0 none, 1 general protection, 2 not present |
| fault_err | output | 16 | Error code for the fault |
| ldt_sel | output | 16 | Local-table register selector |
| ldt_base | output | 64 | Local-table register base |
| ldt_limit | output | 32 | Local-table register byte limit |
| ldt_type | output | 4 | Local-table register descriptor type |
| ldt_valid | output | 1 | Local-table register valid |
| tr_sel | output | 16 | Task register selector |
| tr_base | output | 64 | Task register base |
| tr_limit | output | 32 | Task register byte limit |
| tr_type | output | 4 | Task register descriptor type |
| tr_valid | output | 1 | Task register valid |

## Verification
If the sequencer state is wrong, it shows at the memory port within a cycle or two. Examples are a missing or extra third read, a write on a local-table load, or an address outside the entry. The bench counts and locates every access to catch these. If a latched descriptor word is wrong, the committed base, limit or type differs when `done` pulses. If the check order is wrong, the `fault`/`fault_err` pair is wrong in that same cycle. A commit that slips through on a fault shows as a changed selector or valid flag at the pulse itself.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int SEL_W   = 16;
  localparam int WORD_W  = 32;
  localparam int BASE_W  = 64;
  localparam int LIM_W   = 32;
  localparam int TYPE_W  = 4;
  localparam int NUM_REG = 2;

  localparam int BUSY_BIT    = 9;
  localparam int SYS_BIT     = 12;
  localparam int PRESENT_BIT = 15;
  localparam int GRAN_BIT    = 23;

  localparam logic [TYPE_W-1:0] TY_LDT   = 4'h2;
  localparam logic [TYPE_W-1:0] TY_TSS16 = 4'h1;
  localparam logic [TYPE_W-1:0] TY_TSS32 = 4'h9;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_NP   = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_LO,
    ST_RD_HI,
    ST_RD_EXT,
    ST_CHECK,
    ST_WR_BUSY
  } ld_state_e;
endpackage

// File: rtl/sysreg_selcheck.sv
module sysreg_selcheck
  import sysreg_pkg::*;
#(
  parameter int CPL_W = 2
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [CPL_W-1:0] cpl,
  input  logic             is_tr,
  output logic             fault_hit,
  output logic [SEL_W-1:0] fault_err,
  output logic             null_ok
);
  logic unused_rpl;
  assign unused_rpl = ^sel[1:0];

  always_comb begin
    fault_hit = 1'b0;
    fault_err = '0;
    null_ok   = 1'b0;
    if (cpl != '0) begin
      fault_hit = 1'b1;
    end else if (sel[SEL_W-1:2] == '0) begin
      if (is_tr) fault_hit = 1'b1;
      else       null_ok   = 1'b1;
    end else if (sel[2]) begin
      fault_hit = 1'b1;
      fault_err = {sel[SEL_W-1:2], 2'b00};
    end
  end
endmodule

// File: rtl/sysreg_decode.sv
module sysreg_decode
  import sysreg_pkg::*;
(
  input  logic [WORD_W-1:0] w_lo,
  input  logic [WORD_W-1:0] w_hi,
  input  logic [WORD_W-1:0] w_ext,
  input  logic              is_tr,
  output logic              type_ok,
  output logic              present,
  output logic [BASE_W-1:0] base,
  output logic [LIM_W-1:0]  limit,
  output logic [TYPE_W-1:0] desc_type,
  output logic [WORD_W-1:0] busy_word
);
  logic [19:0] lim20;
  logic        is_sys;

  always_comb begin
    desc_type = w_hi[11:8];
    is_sys    = !w_hi[SYS_BIT];
    if (is_tr) type_ok = is_sys && (desc_type == TY_TSS16 || desc_type == TY_TSS32);
    else       type_ok = is_sys && (desc_type == TY_LDT);
    present   = w_hi[PRESENT_BIT];
    base      = {w_ext, w_hi[31:24], w_hi[7:0], w_lo[31:16]};
    lim20     = {w_hi[19:16], w_lo[15:0]};
    limit     = w_hi[GRAN_BIT] ? {lim20, 12'hFFF} : {12'h000, lim20};
    busy_word = w_hi | (WORD_W'(1) << BUSY_BIT);
  end
endmodule

// File: rtl/sysreg_cache.sv
module sysreg_cache
  import sysreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_full,
  input  logic              wr_null,
  input  logic [SEL_W-1:0]  sel_in,
  input  logic [BASE_W-1:0] base_in,
  input  logic [LIM_W-1:0]  limit_in,
  input  logic [TYPE_W-1:0] type_in,
  output logic [SEL_W-1:0]  sel_o,
  output logic [BASE_W-1:0] base_o,
  output logic [LIM_W-1:0]  limit_o,
  output logic [TYPE_W-1:0] type_o,
  output logic              valid_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o   <= '0;
      base_o  <= '0;
      limit_o <= '0;
      type_o  <= '0;
      valid_o <= 1'b0;
    end else if (wr_full) begin
      sel_o   <= sel_in;
      base_o  <= base_in;
      limit_o <= limit_in;
      type_o  <= type_in;
      valid_o <= 1'b1;
    end else if (wr_null) begin
      sel_o   <= sel_in;
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sysreg_loader.sv
module sysreg_loader
  import sysreg_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CPL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              load_tr,
  input  logic [SEL_W-1:0]  selector,
  input  logic [CPL_W-1:0]  cpl,
  input  logic              long_mode,
  input  logic [ADDR_W-1:0] table_base,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [1:0]        fault,
  output logic [SEL_W-1:0]  fault_err,
  output logic [SEL_W-1:0]  ldt_sel,
  output logic [BASE_W-1:0] ldt_base,
  output logic [LIM_W-1:0]  ldt_limit,
  output logic [TYPE_W-1:0] ldt_type,
  output logic              ldt_valid,
  output logic [SEL_W-1:0]  tr_sel,
  output logic [BASE_W-1:0] tr_base,
  output logic [LIM_W-1:0]  tr_limit,
  output logic [TYPE_W-1:0] tr_type,
  output logic              tr_valid
);
  localparam logic [ADDR_W-1:0] OFS_HI  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_EXT = ADDR_W'(8);
  localparam int               IDX_LSB = 3;

  ld_state_e         st;
  logic              kind_q;
  logic              lm_q;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] entry_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic [WORD_W-1:0] w0_q, w1_q, w2_q;
  logic              done_q;
  fault_e            fault_q;
  logic [SEL_W-1:0]  err_q;

  // selector screening
  logic             pre_hit, null_ok;
  logic [SEL_W-1:0] pre_err;
  sysreg_selcheck #(.CPL_W(CPL_W)) u_selchk (
    .sel(selector), .cpl(cpl), .is_tr(load_tr),
    .fault_hit(pre_hit), .fault_err(pre_err), .null_ok(null_ok)
  );

  // descriptor decode
  logic              type_ok, present;
  logic [BASE_W-1:0] d_base;
  logic [LIM_W-1:0]  d_limit;
  logic [TYPE_W-1:0] d_type;
  logic [WORD_W-1:0] busy_word;
  sysreg_decode u_dec (
    .w_lo(w0_q), .w_hi(w1_q), .w_ext(w2_q), .is_tr(kind_q),
    .type_ok(type_ok), .present(present), .base(d_base), .limit(d_limit),
    .desc_type(d_type), .busy_word(busy_word)
  );

  logic [ADDR_W-1:0] entry_a;
  logic [SEL_W-1:0]  masked_sel;
  assign entry_a    = table_base + {{(ADDR_W-SEL_W){1'b0}}, selector[SEL_W-1:IDX_LSB], 3'b000};
  assign masked_sel = {sel_q[SEL_W-1:2], 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      kind_q  <= 1'b0;
      lm_q    <= 1'b0;
      sel_q   <= '0;
      entry_q <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      w0_q    <= '0;
      w1_q    <= '0;
      w2_q    <= '0;
      done_q  <= 1'b0;
      fault_q <= FLT_NONE;
      err_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          sel_q  <= selector;
          kind_q <= load_tr;
          lm_q   <= long_mode;
          if (pre_hit) begin
            done_q  <= 1'b1;
            fault_q <= FLT_GP;
            err_q   <= pre_err;
          end else if (null_ok) begin
            done_q  <= 1'b1;
            fault_q <= FLT_NONE;
            err_q   <= '0;
          end else begin
            entry_q <= entry_a;
            addr_q  <= entry_a;
            st      <= ST_RD_LO;
          end
        end
        ST_RD_LO: if (mem_ack) begin
          w0_q   <= mem_rdata;
          addr_q <= entry_q + OFS_HI;
          st     <= ST_RD_HI;
        end
        ST_RD_HI: if (mem_ack) begin
          w1_q <= mem_rdata;
          if (lm_q) begin
            addr_q <= entry_q + OFS_EXT;
            st     <= ST_RD_EXT;
          end else begin
            w2_q <= '0;
            st   <= ST_CHECK;
          end
        end
        ST_RD_EXT: if (mem_ack) begin
          w2_q <= mem_rdata;
          st   <= ST_CHECK;
        end
        ST_CHECK: begin
          if (!type_ok) begin
            done_q  <= 1'b1;
            fault_q <= FLT_GP;
            err_q   <= masked_sel;
            st      <= ST_IDLE;
          end else if (!present) begin
            done_q  <= 1'b1;
            fault_q <= FLT_NP;
            err_q   <= masked_sel;
            st      <= ST_IDLE;
          end else if (kind_q) begin
            addr_q  <= entry_q + OFS_HI;
            wdata_q <= busy_word;
            st      <= ST_WR_BUSY;
          end else begin
            done_q  <= 1'b1;
            fault_q <= FLT_NONE;
            err_q   <= '0;
            st      <= ST_IDLE;
          end
        end
        ST_WR_BUSY: if (mem_ack) begin
          done_q  <= 1'b1;
          fault_q <= FLT_NONE;
          err_q   <= '0;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = (st == ST_RD_LO) || (st == ST_RD_HI) || (st == ST_RD_EXT) || (st == ST_WR_BUSY);
  assign mem_we    = (st == ST_WR_BUSY);
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign busy      = (st != ST_IDLE);
  assign done      = done_q;
  assign fault     = fault_q;
  assign fault_err = err_q;

  // register bank: index 0 local table, index 1 task register
  logic [NUM_REG-1:0] commit_v, null_v;
  logic [SEL_W-1:0]   cache_sel;
  assign commit_v[0] = (st == ST_CHECK) && type_ok && present && !kind_q;
  assign commit_v[1] = (st == ST_WR_BUSY) && mem_ack;
  assign null_v[0]   = (st == ST_IDLE) && start && null_ok;
  assign null_v[1]   = 1'b0;
  assign cache_sel   = (st == ST_IDLE) ? selector : sel_q;

  logic [SEL_W-1:0]  r_sel   [NUM_REG];
  logic [BASE_W-1:0] r_base  [NUM_REG];
  logic [LIM_W-1:0]  r_limit [NUM_REG];
  logic [TYPE_W-1:0] r_type  [NUM_REG];
  logic              r_valid [NUM_REG];

  for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
    sysreg_cache u_cache (
      .clk(clk), .rst(rst), .wr_full(commit_v[g]), .wr_null(null_v[g]),
      .sel_in(cache_sel), .base_in(d_base), .limit_in(d_limit), .type_in(d_type),
      .sel_o(r_sel[g]), .base_o(r_base[g]), .limit_o(r_limit[g]),
      .type_o(r_type[g]), .valid_o(r_valid[g])
    );
  end

  assign ldt_sel   = r_sel[0];
  assign ldt_base  = r_base[0];
  assign ldt_limit = r_limit[0];
  assign ldt_type  = r_type[0];
  assign ldt_valid = r_valid[0];
  assign tr_sel    = r_sel[1];
  assign tr_base   = r_base[1];
  assign tr_limit  = r_limit[1];
  assign tr_type   = r_type[1];
  assign tr_valid  = r_valid[1];
endmodule

// File: rtl/sysreg_loader_chk.sv
module sysreg_loader_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        busy,
  input logic        load_tr,
  input logic [1:0]  cpl,
  input logic [15:0] selector,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_wdata,
  input logic        done,
  input logic [1:0]  fault,
  input logic [15:0] fault_err,
  input logic [15:0] ldt_sel,
  input logic        ldt_valid,
  input logic [15:0] tr_sel,
  input logic        tr_valid
);
  // R1
  req_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  // R2
  cpl_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && cpl != 2'd0) |=> (done && fault == 2'd1 && fault_err == 16'h0 && !mem_req));

  // R3
  null_ldt_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !load_tr && cpl == 2'd0 && selector[15:2] == 14'h0)
      |=> (done && fault == 2'd0 && !ldt_valid && !mem_req && ldt_sel == $past(selector)));

  // R4
  null_tr_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && load_tr && cpl == 2'd0 && selector[15:2] == 14'h0)
      |=> (done && fault == 2'd1 && fault_err == 16'h0));

  // R9
  busy_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[9]);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && fault != 2'd0) |-> ($stable(ldt_sel) && $stable(tr_sel) && $stable(ldt_valid) && $stable(tr_valid)));
endmodule

bind sysreg_loader sysreg_loader_chk u_chk (.*);

// File: tb/sim_sysreg_loader.sv
`timescale 1ns/1ps
module sim_sysreg_loader;
  localparam logic [63:0] TBASE = 64'h0000_0012_3456_7800;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, load_tr = 1'b0, long_mode = 1'b0;
  logic [15:0] selector = '0;
  logic [1:0]  cpl = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic        busy, done;
  logic [1:0]  fault;
  logic [15:0] fault_err, ldt_sel, tr_sel;
  logic [63:0] ldt_base, tr_base;
  logic [31:0] ldt_limit, tr_limit;
  logic [3:0]  ldt_type, tr_type;
  logic        ldt_valid, tr_valid;

  always #4 clk = ~clk;

  sysreg_loader u0 (
    .clk(clk), .rst(rst), .start(start), .load_tr(load_tr), .selector(selector),
    .cpl(cpl), .long_mode(long_mode), .table_base(TBASE),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .fault(fault), .fault_err(fault_err),
    .ldt_sel(ldt_sel), .ldt_base(ldt_base), .ldt_limit(ldt_limit), .ldt_type(ldt_type), .ldt_valid(ldt_valid),
    .tr_sel(tr_sel), .tr_base(tr_base), .tr_limit(tr_limit), .tr_type(tr_type), .tr_valid(tr_valid)
  );

  int checks = 0;
  int errs = 0;
  int acc_cnt = 0;
  logic [63:0] last_waddr = '0;
  logic [31:0] mem [64];

  // memory model: acknowledges each request half a cycle later
  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack = 1'b1;
      acc_cnt++;
      if (mem_addr[63:8] != TBASE[63:8]) begin
        errs++;
        $display("FAIL R6 access outside table act=%h exp=%h..", mem_addr, TBASE[63:8]);
      end
      if (mem_we) begin
        mem[mem_addr[7:2]] = mem_wdata;
        last_waddr = mem_addr;
      end else begin
        mem_rdata = mem[mem_addr[7:2]];
      end
    end else begin
      mem_ack = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic tr, input logic lm, input logic [1:0] c, input logic [15:0] s);
    logic got;
    @(negedge clk);
    load_tr = tr; long_mode = lm; cpl = c; selector = s; acc_cnt = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (done) begin got = 1'b1; break; end
      @(negedge clk);
    end
    chk("R11 done seen", {63'h0, got}, 64'h1);
  endtask

  typedef struct packed {
    logic        tr;
    logic        lm;
    logic [1:0]  cpl;
    logic [15:0] sel;
    logic [31:0] w0;
    logic [31:0] w1;
    logic [31:0] w2;
    logic [1:0]  ef;
    logic [15:0] ee;
    logic [63:0] eb;
    logic [31:0] el;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 2'd0, 16'h0010, 32'h5678_0FFF, 32'h1200_8234, 32'hFFFF_FFFF, 2'd0, 16'h0000, 64'h0000_0000_1234_5678, 32'h0000_0FFF},
    '{1'b0, 1'b1, 2'd0, 16'h0018, 32'hAAAA_0001, 32'hBB83_82CC, 32'hDEAD_BEEF, 2'd0, 16'h0000, 64'hDEAD_BEEF_BBCC_AAAA, 32'h3000_1FFF},
    '{1'b1, 1'b0, 2'd0, 16'h0020, 32'h0000_0067, 32'h0000_8900, 32'hFFFF_FFFF, 2'd0, 16'h0000, 64'h0,                   32'h0000_0067},
    '{1'b1, 1'b1, 2'd0, 16'h0028, 32'h1111_2222, 32'h3300_8144, 32'h0000_0001, 2'd0, 16'h0000, 64'h0000_0001_3344_1111, 32'h0000_2222},
    '{1'b0, 1'b0, 2'd0, 16'h0030, 32'h0,         32'h0000_8900, 32'h0,         2'd1, 16'h0030, 64'h0, 32'h0},
    '{1'b1, 1'b0, 2'd0, 16'h003B, 32'h0,         32'h0000_8B00, 32'h0,         2'd1, 16'h0038, 64'h0, 32'h0},
    '{1'b0, 1'b0, 2'd0, 16'h0042, 32'h0,         32'h0000_0200, 32'h0,         2'd2, 16'h0040, 64'h0, 32'h0},
    '{1'b1, 1'b0, 2'd0, 16'h0048, 32'h0,         32'h0000_1A00, 32'h0,         2'd1, 16'h0048, 64'h0, 32'h0},
    '{1'b1, 1'b1, 2'd0, 16'h0051, 32'h0,         32'h0000_0100, 32'h0,         2'd2, 16'h0050, 64'h0, 32'h0},
    '{1'b0, 1'b0, 2'd0, 16'h0058, 32'h0,         32'h0000_9200, 32'h0,         2'd1, 16'h0058, 64'h0, 32'h0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL R11 watchdog act=timeout exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    logic [15:0] s_ls, s_ts;
    logic        s_lv, s_tv;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ldt_valid", {63'h0, ldt_valid}, 64'h0);
    chk("R1 tr_valid", {63'h0, tr_valid}, 64'h0);
    chk("R1 fault", {62'h0, fault}, 64'h0);
    chk("R1 busy/done/req", {61'h0, busy, done, mem_req}, 64'h0);
    chk("R1 ldt_base", ldt_base, 64'h0);

    // vector table: R6 R7 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      automatic vec_t v = VECS[i];
      automatic int idx = int'(v.sel[15:3]);
      mem[idx*2]   = v.w0;
      mem[idx*2+1] = v.w1;
      mem[idx*2+2] = v.w2;
      s_ls = ldt_sel; s_lv = ldt_valid; s_ts = tr_sel; s_tv = tr_valid;
      run(v.tr, v.lm, v.cpl, v.sel);
      chk("R7 R8 fault code", {62'h0, fault}, {62'h0, v.ef});
      chk("R7 R8 error code", {48'h0, fault_err}, {48'h0, v.ee});
      if (v.ef == 2'd0) begin
        if (v.tr) begin
          chk("R10 tr_sel", {48'h0, tr_sel}, {48'h0, v.sel});
          chk("R10 tr_base", tr_base, v.eb);
          chk("R10 tr_limit", {32'h0, tr_limit}, {32'h0, v.el});
          chk("R10 tr_type", {60'h0, tr_type}, {60'h0, v.w1[11:8]});
          chk("R10 tr_valid", {63'h0, tr_valid}, 64'h1);
          chk("R9 busy word", {32'h0, mem[idx*2+1]}, {32'h0, v.w1 | 32'h200});
          chk("R9 write addr", last_waddr, TBASE + 64'(idx*8 + 4));
          chk("R6 access count", 64'(acc_cnt), v.lm ? 64'd4 : 64'd3);
        end else begin
          chk("R10 ldt_sel", {48'h0, ldt_sel}, {48'h0, v.sel});
          chk("R10 ldt_base", ldt_base, v.eb);
          chk("R10 ldt_limit", {32'h0, ldt_limit}, {32'h0, v.el});
          chk("R10 ldt_type", {60'h0, ldt_type}, {60'h0, v.w1[11:8]});
          chk("R10 ldt_valid", {63'h0, ldt_valid}, 64'h1);
          chk("R6 access count", 64'(acc_cnt), v.lm ? 64'd3 : 64'd2);
        end
      end else begin
        chk("R11 regs held", {30'h0, ldt_sel, tr_sel, ldt_valid, tr_valid},
            {30'h0, s_ls, s_ts, s_lv, s_tv});
      end
      @(negedge clk);
      chk("R11 done pulse", {63'h0, done}, 64'h0);
    end

    // R2 privilege not zero
    s_ls = ldt_sel;
    run(1'b0, 1'b0, 2'd3, 16'h0010);
    chk("R2 fault", {62'h0, fault}, 64'h1);
    chk("R2 err", {48'h0, fault_err}, 64'h0);
    chk("R2 no access", 64'(acc_cnt), 64'h0);
    chk("R2 ldt_sel held", {48'h0, ldt_sel}, {48'h0, s_ls});

    // R2 beats R5: privilege fault with table bit also set
    run(1'b0, 1'b0, 2'd2, 16'h001C);
    chk("R2 priority err", {48'h0, fault_err}, 64'h0);

    // R3 null local-table load
    run(1'b0, 1'b0, 2'd0, 16'h0003);
    chk("R3 fault", {62'h0, fault}, 64'h0);
    chk("R3 ldt_sel", {48'h0, ldt_sel}, 64'h3);
    chk("R3 ldt_valid", {63'h0, ldt_valid}, 64'h0);
    chk("R3 no access", 64'(acc_cnt), 64'h0);

    // R4 null task-register load
    run(1'b1, 1'b0, 2'd0, 16'h0002);
    chk("R4 fault", {62'h0, fault}, 64'h1);
    chk("R4 err", {48'h0, fault_err}, 64'h0);
    chk("R4 tr_valid held", {63'h0, tr_valid}, 64'h1);
    chk("R4 no access", 64'(acc_cnt), 64'h0);

    // R5 table bit set
    run(1'b0, 1'b0, 2'd0, 16'h0017);
    chk("R5 fault", {62'h0, fault}, 64'h1);
    chk("R5 err", {48'h0, fault_err}, 64'h0014);
    chk("R5 no access", 64'(acc_cnt), 64'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule